// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block turns a programmed chain of comparator-match events into a trigger point for a trace buffer and a breakpoint request for a CPU. Software arms it with a one-cycle strobe. The sequencer then enters the first of three middle steps. From each middle step, a configured comparator channel moves it to any other middle step, or to the final step. In the final step it either fires a trace trigger and waits for the trace session to finish, or it raises a breakpoint request. In both cases it then disarms.

Several events bypass the programmed chain, and they are resolved by a fixed priority:
- a disarm strobe
- a tag hit
- a coprocessor software breakpoint
- a match on a channel marked for immediate break
- a software force-trigger

A match on an immediate-break channel passes through the final step for exactly one cycle and then returns to the disarmed step. All outputs are registered. A pulse caused by an event sampled at clock edge k is high during the cycle that follows edge k, in the same cycle that the state field shows the new step.

Top module: `trig_chain_seq`

## Requirements
- R1: After reset, `stateFlags` is 000 and `armed`, `brkReq`, `traceTrig` and `traceAbort` are all 0.
- R2: In step 000, an `armSet` pulse without `armClr` moves the sequencer to step 001 and sets `armed` at the next edge. While armed, `armSet` has no effect. `armed` is 1 exactly when `stateFlags` is not 000.
- R3: An `armClr` pulse in any armed step returns the sequencer to 000 and clears `armed`, with no other output pulse. It overrides every other event.
- R4: The state codes are: 000 disarmed, 001/010/011 middle steps 1 to 3, and 100 final. `stepCfg` holds one 4-bit slot per middle step, with step k in bits [4k-1:4k-4]. In each slot, bits [3:2] select a channel and bits [1:0] give the target: 01, 10 and 11 mean steps 1 to 3, and 00 means final. A match on the selected channel moves to the target at the next edge. A match on any other channel leaves the step unchanged.
- R5: When the final step is entered with `traceEn`=0, `brkReq` pulses in the entry cycle if `brkEn`=1. The next cycle shows 000 with `armed`=0.
- R6: When the final step is entered with `traceEn`=1, `traceTrig` pulses in the entry cycle. The step stays at 100 until `traceDone` is sampled high. The cycle after that shows 000, disarmed, and `brkReq` pulses if `brkEn`=1.
- R7: A `forceTrig` pulse in a middle step enters the final step with the actions of R5/R6. While disarmed it is ignored.
- R8: A `tagHit` in any armed step returns to 000 and disarms. It pulses `brkReq` if `brkEn`=1 and pulses `traceAbort` if `traceEn`=1.
- R9: `copBrkReq` with `copBrkEn`=1 in an armed step returns to 000, disarms and pulses `brkReq` whatever the value of `brkEn`. With `copBrkEn`=0 it is ignored.
- R10: In a middle step, a match on a channel whose `chanBrkEn` bit is set shows 100 for exactly one cycle and then 000 with `armed`=0. It pulses `brkReq` in the 100 cycle if `brkEn`=1 and never pulses `traceTrig`, even with `traceEn`=1.
- R11: Events in the same cycle resolve in this order, highest first: disarm, tag hit, coprocessor break, immediate-break match, force-trigger, configured step. The final step ignores the last three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armSet | input | 1 | Arm strobe |
| armClr | input | 1 | Disarm strobe |
| forceTrig | input | 1 | Software force-trigger strobe |
| chanMatch | input | NUM_CH | Comparator match per channel |
| chanBrkEn | input | NUM_CH | Immediate-break enable per channel |
| tagHit | input | 1 | Tagged-fetch hit |
| copBrkReq | input | 1 | Coprocessor software breakpoint request |
| copBrkEn | input | 1 | Enable for coprocessor breakpoint |
| brkEn | input | 1 | Breakpoint requests enabled |
| traceEn | input | 1 | A trace source is enabled |
| traceDone | input | 1 | Trace session complete |
| stepCfg | input | 3*(SEL_W+2) | Per-middle-step channel select and target |
| stateFlags | output | 3 | Current step code |
| traceTrig | output | 1 | Trace trigger pulse |
| traceAbort | output | 1 | Trace abort pulse |
| brkReq | output | 1 | Breakpoint request pulse |
| armed | output | 1 | Sequencer armed |

## Verification
A wrong internal step appears on `stateFlags` in the cycle right after the faulty edge, because the field is the state register itself. The `armed` output exposes a disagreement between the arm flag and the step in that same cycle. A wrong priority decision or a missed final-step action shows up as a missing or extra one-cycle pulse on `brkReq`, `traceTrig` or `traceAbort`, aligned with the step change. A final step that is held too long or too briefly is visible one cycle later, as 100 persisting or vanishing early. The bench compares all five outputs after every edge against a behavioural model, so any such divergence is reported within one cycle.

// File: rtl/trig_chain_pkg.sv
`timescale 1ns/1ps
package trig_chain_pkg;
  localparam int NUM_MID = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_ONE   = 3'b001,
    ST_TWO   = 3'b010,
    ST_THREE = 3'b011,
    ST_FINAL = 3'b100
  } seqState_t;

  // Qualified events offered by the datapath to the control
  typedef struct packed {
    logic      armReq;
    logic      disarmReq;
    logic      tagReq;
    logic      copReq;
    logic      brkHit;
    logic      forceReq;
    logic      stepHit;
    seqState_t stepTo;
    logic      brkOn;
    logic      traceOn;
    logic      doneReq;
  } seqEvt_t;

  // Strobes from the control to the datapath registers
  typedef struct packed {
    logic armNow;
    logic toIdle;
    logic brkPulse;
    logic trigPulse;
    logic abortPulse;
    logic startWait;
  } seqStrb_t;
endpackage

// File: rtl/trig_chain_dp.sv
`timescale 1ns/1ps
module trig_chain_dp
  import trig_chain_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2,
  localparam int CFG_W = SEL_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     armSet,
  input  logic                     armClr,
  input  logic                     forceTrig,
  input  logic [NUM_CH-1:0]        chanMatch,
  input  logic [NUM_CH-1:0]        chanBrkEn,
  input  logic                     tagHit,
  input  logic                     copBrkReq,
  input  logic                     copBrkEn,
  input  logic                     brkEn,
  input  logic                     traceEn,
  input  logic                     traceDone,
  input  logic [NUM_MID*CFG_W-1:0] stepCfg,
  input  seqState_t                curState,
  input  seqStrb_t                 strb,
  output seqEvt_t                  evt,
  output logic                     waitTrace,
  output logic                     brkReq,
  output logic                     traceTrig,
  output logic                     traceAbort,
  output logic                     armed
);
  logic [SEL_W-1:0] slotSel  [NUM_MID];
  logic [1:0]       slotNext [NUM_MID];

  for (genvar k = 0; k < NUM_MID; k++) begin : g_slot
    assign slotSel[k]  = stepCfg[k*CFG_W+2 +: SEL_W];
    assign slotNext[k] = stepCfg[k*CFG_W +: 2];
  end

  logic [SEL_W-1:0] curSel;
  logic [1:0]       curNext;
  logic             inMid;

  always_comb begin
    curSel  = '0;
    curNext = '0;
    inMid   = 1'b0;
    case (curState)
      ST_ONE:   begin curSel = slotSel[0]; curNext = slotNext[0]; inMid = 1'b1; end
      ST_TWO:   begin curSel = slotSel[1]; curNext = slotNext[1]; inMid = 1'b1; end
      ST_THREE: begin curSel = slotSel[2]; curNext = slotNext[2]; inMid = 1'b1; end
      default:  ;
    endcase
  end

  logic selMatch;
  always_comb begin
    selMatch = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (curSel == c[SEL_W-1:0]) selMatch = chanMatch[c];
  end

  always_comb begin
    evt.armReq    = armSet;
    evt.disarmReq = armClr;
    evt.tagReq    = tagHit;
    evt.copReq    = copBrkReq & copBrkEn;
    evt.brkHit    = |(chanMatch & chanBrkEn);
    evt.forceReq  = forceTrig;
    evt.stepHit   = inMid & selMatch;
    evt.stepTo    = (curNext == 2'b00) ? ST_FINAL : seqState_t'({1'b0, curNext});
    evt.brkOn     = brkEn;
    evt.traceOn   = traceEn;
    evt.doneReq   = traceDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkReq     <= 1'b0;
      traceTrig  <= 1'b0;
      traceAbort <= 1'b0;
      armed      <= 1'b0;
      waitTrace  <= 1'b0;
    end else begin
      brkReq     <= strb.brkPulse;
      traceTrig  <= strb.trigPulse;
      traceAbort <= strb.abortPulse;
      if (strb.toIdle)      armed <= 1'b0;
      else if (strb.armNow) armed <= 1'b1;
      if (strb.toIdle)         waitTrace <= 1'b0;
      else if (strb.startWait) waitTrace <= 1'b1;
    end
  end

  // R2: arm flag tracks the step register held in the control
  p_armed_state_r2: assert property (@(posedge clk) disable iff (!rstN)
    armed == (curState != ST_IDLE));
  // R6: trace trigger only alongside the final step
  p_trig_final_r6: assert property (@(posedge clk) disable iff (!rstN)
    traceTrig |-> (curState == ST_FINAL));
  // R6: waiting for trace completion only in the final step
  p_wait_final_r6: assert property (@(posedge clk) disable iff (!rstN)
    waitTrace |-> (curState == ST_FINAL));
  // R8: abort pulse accompanies the return to disarmed
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    traceAbort |-> (curState == ST_IDLE));
endmodule

// File: rtl/trig_chain_ctrl.sv
`timescale 1ns/1ps
module trig_chain_ctrl
  import trig_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  seqEvt_t   evt,
  input  logic      waitTrace,
  output seqState_t curState,
  output seqStrb_t  strb
);
  seqState_t nextState;

  function automatic seqStrb_t finalEntry(input seqStrb_t s, input logic traceOn,
                                          input logic brkOn);
    seqStrb_t r = s;
    if (traceOn) begin
      r.trigPulse = 1'b1;
      r.startWait = 1'b1;
    end else begin
      r.brkPulse = brkOn;
    end
    return r;
  endfunction

  always_comb begin
    nextState = curState;
    strb      = '0;
    case (curState)
      ST_IDLE: begin
        if (evt.armReq && !evt.disarmReq) begin
          nextState   = ST_ONE;
          strb.armNow = 1'b1;
        end
      end
      ST_ONE, ST_TWO, ST_THREE, ST_FINAL: begin
        if (evt.disarmReq) begin
          nextState   = ST_IDLE;
          strb.toIdle = 1'b1;
        end else if (evt.tagReq) begin
          nextState       = ST_IDLE;
          strb.toIdle     = 1'b1;
          strb.brkPulse   = evt.brkOn;
          strb.abortPulse = evt.traceOn;
        end else if (evt.copReq) begin
          nextState     = ST_IDLE;
          strb.toIdle   = 1'b1;
          strb.brkPulse = 1'b1;
        end else if (curState == ST_FINAL) begin
          if (!waitTrace || evt.doneReq) begin
            nextState     = ST_IDLE;
            strb.toIdle   = 1'b1;
            strb.brkPulse = waitTrace & evt.brkOn;
          end
        end else if (evt.brkHit) begin
          nextState     = ST_FINAL;
          strb.brkPulse = evt.brkOn;
        end else if (evt.forceReq) begin
          nextState = ST_FINAL;
          strb      = finalEntry(strb, evt.traceOn, evt.brkOn);
        end else if (evt.stepHit) begin
          nextState = evt.stepTo;
          if (evt.stepTo == ST_FINAL)
            strb = finalEntry(strb, evt.traceOn, evt.brkOn);
        end
      end
      default: begin
        nextState   = ST_IDLE;
        strb.toIdle = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  // R2: arming enters the first middle step
  p_arm_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && evt.armReq && !evt.disarmReq) |=> (curState == ST_ONE));
  // R3: disarm wins from every armed step
  p_disarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_IDLE && evt.disarmReq) |=> (curState == ST_IDLE));
  // R5: the final step can only hold or fall to disarmed
  p_final_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_FINAL) |=> (curState == ST_FINAL || curState == ST_IDLE));
  // R8: tag hit drops to disarmed unless disarm already did
  p_tag_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_IDLE && evt.tagReq) |=> (curState == ST_IDLE));
  // R10: break-channel match passes through final for one cycle
  p_brk_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_IDLE && curState != ST_FINAL && !evt.disarmReq && !evt.tagReq
     && !evt.copReq && evt.brkHit) |=> (curState == ST_FINAL) ##1 (curState == ST_IDLE));
endmodule

// File: rtl/trig_chain_seq.sv
`timescale 1ns/1ps
module trig_chain_seq
  import trig_chain_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CFG_W = SEL_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     armSet,
  input  logic                     armClr,
  input  logic                     forceTrig,
  input  logic [NUM_CH-1:0]        chanMatch,
  input  logic [NUM_CH-1:0]        chanBrkEn,
  input  logic                     tagHit,
  input  logic                     copBrkReq,
  input  logic                     copBrkEn,
  input  logic                     brkEn,
  input  logic                     traceEn,
  input  logic                     traceDone,
  input  logic [NUM_MID*CFG_W-1:0] stepCfg,
  output logic [2:0]               stateFlags,
  output logic                     traceTrig,
  output logic                     traceAbort,
  output logic                     brkReq,
  output logic                     armed
);
  seqState_t curState;
  seqEvt_t   evt;
  seqStrb_t  strb;
  logic      waitTrace;

  trig_chain_dp #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr), .forceTrig(forceTrig),
    .chanMatch(chanMatch), .chanBrkEn(chanBrkEn), .tagHit(tagHit),
    .copBrkReq(copBrkReq), .copBrkEn(copBrkEn), .brkEn(brkEn), .traceEn(traceEn),
    .traceDone(traceDone), .stepCfg(stepCfg), .curState(curState), .strb(strb),
    .evt(evt), .waitTrace(waitTrace), .brkReq(brkReq), .traceTrig(traceTrig),
    .traceAbort(traceAbort), .armed(armed)
  );

  trig_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .waitTrace(waitTrace),
    .curState(curState), .strb(strb)
  );

  assign stateFlags = curState;
endmodule

// File: tb/trig_chain_seq_test.sv
`timescale 1ns/1ps
module trig_chain_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armSet, armClr, forceTrig, tagHit, copBrkReq, copBrkEn, brkEn, traceEn, traceDone;
  logic [3:0]  chanMatch, chanBrkEn;
  logic [11:0] stepCfg;
  logic [2:0]  stateFlags;
  logic traceTrig, traceAbort, brkReq, armed;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [2:0] mSt;
  logic mArmed, mHold, mBrk, mTrig, mAbort;

  always #2.5 clk = ~clk;

  trig_chain_seq uut (
    .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr), .forceTrig(forceTrig),
    .chanMatch(chanMatch), .chanBrkEn(chanBrkEn), .tagHit(tagHit), .copBrkReq(copBrkReq),
    .copBrkEn(copBrkEn), .brkEn(brkEn), .traceEn(traceEn), .traceDone(traceDone),
    .stepCfg(stepCfg), .stateFlags(stateFlags), .traceTrig(traceTrig),
    .traceAbort(traceAbort), .brkReq(brkReq), .armed(armed)
  );

  function automatic logic [3:0] mkSlot(input logic [1:0] ch, input logic [1:0] tgt);
    return {ch, tgt};
  endfunction

  task automatic enterFinalModel(output logic [2:0] n, inout logic b, inout logic t,
                                 inout logic h);
    n = 3'd4;
    if (traceEn) begin t = 1'b1; h = 1'b1; end
    else b = brkEn;
  endtask

  // Expected next outputs from the requirements, using the inputs now applied
  task automatic modelEdge();
    logic [2:0] n; logic b, t, a, ar, h;
    logic [3:0] slot;
    n = mSt; b = 0; t = 0; a = 0; ar = mArmed; h = mHold;
    if (mSt == 3'd0) begin
      if (armSet && !armClr) begin n = 3'd1; ar = 1; end
    end else if (armClr) begin n = 0; ar = 0; h = 0;
    end else if (tagHit) begin n = 0; ar = 0; h = 0; b = brkEn; a = traceEn;
    end else if (copBrkReq && copBrkEn) begin n = 0; ar = 0; h = 0; b = 1;
    end else if (mSt == 3'd4) begin
      if (!mHold || traceDone) begin n = 0; ar = 0; b = mHold && brkEn; h = 0; end
    end else if (|(chanMatch & chanBrkEn)) begin n = 3'd4; b = brkEn;
    end else if (forceTrig) begin enterFinalModel(n, b, t, h);
    end else begin
      slot = stepCfg[(mSt-1)*4 +: 4];
      if (chanMatch[slot[3:2]]) begin
        if (slot[1:0] == 2'b00) enterFinalModel(n, b, t, h);
        else n = {1'b0, slot[1:0]};
      end
    end
    mSt = n; mBrk = b; mTrig = t; mAbort = a; mArmed = ar; mHold = h;
  endtask

  task automatic compare(input string req);
    checks++;
    if (stateFlags !== mSt || armed !== mArmed || brkReq !== mBrk ||
        traceTrig !== mTrig || traceAbort !== mAbort) begin
      errors++;
      $display("FAIL %s: st/arm/brk/trig/abort actual %0d %b %b %b %b expected %0d %b %b %b %b",
               req, stateFlags, armed, brkReq, traceTrig, traceAbort,
               mSt, mArmed, mBrk, mTrig, mAbort);
    end
  endtask

  task automatic expectState(input string req, input logic [2:0] e);
    checks++;
    if (stateFlags !== e) begin
      errors++;
      $display("FAIL %s: stateFlags actual %0d expected %0d", req, stateFlags, e);
    end
  endtask

  task automatic quiet();
    armSet = 0; armClr = 0; forceTrig = 0; tagHit = 0; copBrkReq = 0;
    chanMatch = 0; traceDone = 0;
  endtask

  task automatic tick(input string req);
    modelEdge();
    @(posedge clk); #1;
    compare(req);
    quiet();
  endtask

  task automatic armIt();
    armSet = 1; tick("R2");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    quiet();
    chanBrkEn = 0; copBrkEn = 0; brkEn = 0; traceEn = 0;
    // slot for step3: ch0 -> step2; step2: ch1 -> final; step1: ch2 -> step3
    stepCfg = {mkSlot(2'd0, 2'b10), mkSlot(2'd1, 2'b00), mkSlot(2'd2, 2'b11)};
    mSt = 0; mArmed = 0; mHold = 0; mBrk = 0; mTrig = 0; mAbort = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    expectState("R1", 3'd0);
    rstN = 1;
    @(posedge clk); #1;

    // R2 arm then repeated arm ignored
    armIt(); expectState("R2", 3'd1);
    armSet = 1; tick("R2"); expectState("R2", 3'd1);

    // R4 unselected channels, then chain 1->3->2->final; R5 without trace
    brkEn = 1; traceEn = 0;
    chanMatch = 4'b1011; tick("R4"); expectState("R4", 3'd1);
    chanMatch = 4'b0100; tick("R4"); expectState("R4", 3'd3);
    chanMatch = 4'b0001; tick("R4"); expectState("R4", 3'd2);
    chanMatch = 4'b0010; tick("R5"); expectState("R5", 3'd4);
    tick("R5"); expectState("R5", 3'd0);

    // R6/R7 force with tracing on
    armIt(); traceEn = 1;
    forceTrig = 1; tick("R7"); expectState("R7", 3'd4);
    tick("R6"); tick("R6"); expectState("R6", 3'd4);
    traceDone = 1; tick("R6"); expectState("R6", 3'd0);
    forceTrig = 1; tick("R7"); expectState("R7", 3'd0);

    // R3 disarm from step3
    armIt(); chanMatch = 4'b0100; tick("R4");
    armClr = 1; tick("R3"); expectState("R3", 3'd0);

    // R8 tag hit
    armIt(); tagHit = 1; tick("R8");

    // R9 coprocessor break, disabled then enabled
    armIt(); copBrkReq = 1; copBrkEn = 0; tick("R9"); expectState("R9", 3'd1);
    brkEn = 0; copBrkEn = 1; copBrkReq = 1; tick("R9"); expectState("R9", 3'd0);

    // R10 break-channel pass with trace on and breaks off
    armIt(); chanBrkEn = 4'b1000; traceEn = 1; brkEn = 0;
    chanMatch = 4'b1000; tick("R10"); expectState("R10", 3'd4);
    tick("R10"); expectState("R10", 3'd0);
    armIt(); brkEn = 1; chanMatch = 4'b1000; tick("R10");
    chanMatch = 4'b1000; tick("R10");

    // R11 priority pairs
    armIt(); armClr = 1; tagHit = 1; tick("R11");
    armIt(); brkEn = 0; tagHit = 1; copBrkReq = 1; tick("R11");
    armIt(); copBrkReq = 1; chanMatch = 4'b1000; tick("R11");
    armIt(); traceEn = 1; chanMatch = 4'b1000; forceTrig = 1; tick("R11");
    tick("R11");
    armIt(); chanBrkEn = 4'b0000; forceTrig = 1; chanMatch = 4'b0100; tick("R11");
    expectState("R11", 3'd4);
    traceDone = 1; tick("R11");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) begin
        stepCfg   = 12'($urandom);
        chanBrkEn = (($urandom % 4) == 0) ? 4'(1 << ($urandom % 4)) : 4'b0;
      end
      armSet    = ($urandom % 4) == 0;
      armClr    = ($urandom % 24) == 0;
      forceTrig = ($urandom % 16) == 0;
      tagHit    = ($urandom % 40) == 0;
      copBrkReq = ($urandom % 20) == 0;
      copBrkEn  = ($urandom % 2) == 0;
      brkEn     = ($urandom % 2) == 0;
      traceEn   = ($urandom % 2) == 0;
      traceDone = ($urandom % 6) == 0;
      chanMatch = 4'($urandom) & 4'($urandom);
      tick("R11");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule